// File: doc/BRIEF.md
# Redundant Store Output Comparator

This block guards the exit of a region in which a program runs twice, once as a leading thread and once as a trailing thread. Each thread commits its stores, in program order, into a private queue. The block pairs the two queue heads and checks that they agree on both address and data. It passes a single copy to the data cache write port only when they agree. Nothing leaves the region on the word of one thread alone.

Uncached loads also leave the region, so their addresses are checked in the same way. A request goes out only when both threads present the same uncached address. Cached loads are acknowledged at once without any comparison. Any disagreement sets a sticky fault flag. While the flag is set, no store and no uncached request is released and both queues keep their contents. A pulse on the clear input lowers the flag, and recovery is left to logic outside the block.

Top module: `redundant_store_cmp`

## Requirements
- R1: A store is offered on the cache write port (`cw_valid_o` high) only when both queue heads are valid and their addresses and data are equal. The offered address and data are those of the heads.
- R2: While either queue is empty, no store is offered, and the head of the other queue waits.
- R3: A store accepted by the cache (`cw_valid_o` and `cw_ready_i` both high at a clock edge) removes the head of both queues at that edge. In the next cycle the following pair is compared.
- R4: When both heads are valid but differ in address or data, `fault_o` rises one clock later. Neither entry is removed. While the heads still differ, `fault_o` stays high even when `fault_clr_i` is pulsed.
- R5: While `fault_o` is high, neither `cw_valid_o` nor `ul_req_valid_o` is asserted.
- R6: When `fault_clr_i` is high in a cycle with no disagreement, `fault_o` is low from the next clock. Releases then resume.
- R7: Each queue holds DEPTH entries (default 64). Its full output is high exactly when it holds DEPTH entries, and a push offered while it is full is dropped.
- R8: An uncached load request (`ul_req_valid_o`) is raised only when both threads present a valid uncached load (`*_ld_valid_i` and `*_ld_uncached_i` high) with equal addresses. Its address is the shared address. Both thread acknowledges go high in the cycle in which `ul_req_ready_i` accepts it.
- R9: When both threads present uncached loads with different addresses, `fault_o` rises one clock later.
- R10: A valid load with `*_ld_uncached_i` low is acknowledged in the same cycle, whatever the other thread does. It never causes an uncached request or a fault.
- R11: While a store is offered and `cw_ready_i` is low, the offer and its address and data stay unchanged until it is accepted, unless a fault intervenes.
- R12: After reset both queues are empty, and `fault_o`, `cw_valid_o`, `ul_req_valid_o` and both full outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lead_st_valid_i | input | 1 | Leading thread commits a store |
| lead_st_addr_i | input | AW | Leading store address |
| lead_st_data_i | input | DW | Leading store data |
| lead_full_o | output | 1 | Leading queue full |
| trail_st_valid_i | input | 1 | Trailing thread commits a store |
| trail_st_addr_i | input | AW | Trailing store address |
| trail_st_data_i | input | DW | Trailing store data |
| trail_full_o | output | 1 | Trailing queue full |
| cw_valid_o | output | 1 | Agreed store offered to the cache |
| cw_addr_o | output | AW | Offered store address |
| cw_data_o | output | DW | Offered store data |
| cw_ready_i | input | 1 | Cache accepts the offered store |
| lead_ld_valid_i | input | 1 | Leading thread issues a load |
| lead_ld_uncached_i | input | 1 | Leading load is uncached |
| lead_ld_addr_i | input | AW | Leading load address |
| lead_ld_ack_o | output | 1 | Leading load acknowledged |
| trail_ld_valid_i | input | 1 | Trailing thread issues a load |
| trail_ld_uncached_i | input | 1 | Trailing load is uncached |
| trail_ld_addr_i | input | AW | Trailing load address |
| trail_ld_ack_o | output | 1 | Trailing load acknowledged |
| ul_req_valid_o | output | 1 | Single uncached load request |
| ul_req_addr_o | output | AW | Uncached load request address |
| ul_req_ready_i | input | 1 | Uncached request accepted |
| fault_clr_i | input | 1 | Clears the fault flag |
| fault_o | output | 1 | Sticky disagreement flag |

## Verification
The assertions check on every cycle the properties that hold at the ports:
- no release or uncached request while a fault is raised;
- no release while either queue is empty;
- both queues are popped together;
- a pending offer holds steady;
- a fault is sticky;
- an uncached request mirrors two agreeing uncached loads;
- cached loads are acknowledged at once.

Other behaviour can only be shown by the bench's scenarios. These cover dropping a push into a full queue, the exact order of released pairs after many skewed pushes, the fault that persists past a clear while the heads still differ, and the resumption of releases after a clear.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   // Outcome of comparing the two queue heads in one cycle
   typedef enum logic [1:0] {
      VD_WAIT   = 2'd0,   // at least one head missing
      VD_AGREE  = 2'd1,   // heads equal, release allowed
      VD_DIFFER = 2'd2,   // heads present and unequal
      VD_HELD   = 2'd3    // heads equal but fault blocks release
   } verdict_e;

   function automatic logic [1:0] verdict_bits(input verdict_e v);
      return 2'(v);
   endfunction

endpackage

// File: rtl/rsc_queue.sv
module rsc_queue #(
   parameter int DEPTH = 64,
   parameter int W     = 96
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rsc_queue: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("rsc_queue: W must be positive");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             push_ok, pop_ok;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/rsc_store_cmp.sv
module rsc_store_cmp #(
   parameter int AW      = 32,
   parameter int DW      = 64,
   parameter int CHUNK_W = 16
) (
   input  logic          l_empty,
   input  logic          t_empty,
   input  logic [AW-1:0] l_addr,
   input  logic [AW-1:0] t_addr,
   input  logic [DW-1:0] l_data,
   input  logic [DW-1:0] t_data,
   input  logic          fault,
   input  logic          cw_ready,
   output logic          cw_valid,
   output logic [AW-1:0] cw_addr,
   output logic [DW-1:0] cw_data,
   output logic          pop_l,
   output logic          pop_t,
   output logic          mismatch
);
   import rsc_pkg::*;

   localparam int N_CHUNK = (DW + CHUNK_W - 1) / CHUNK_W;
   localparam int PAD_W   = N_CHUNK * CHUNK_W;

   generate
      if (CHUNK_W < 1) begin : g_bad_chunk
         $error("rsc_store_cmp: CHUNK_W must be positive");
      end
   endgenerate

   logic [PAD_W-1:0]   l_pad, t_pad;
   logic [N_CHUNK-1:0] chunk_eq;
   logic               data_eq, addr_eq, both;
   verdict_e           verdict;

   assign l_pad = PAD_W'(l_data);
   assign t_pad = PAD_W'(t_data);

   // Wide data is compared in slices and reduced, keeping each compare shallow
   generate
      for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
         assign chunk_eq[g] = (l_pad[g*CHUNK_W +: CHUNK_W] == t_pad[g*CHUNK_W +: CHUNK_W]);
      end
   endgenerate

   assign data_eq = &chunk_eq;
   assign addr_eq = (l_addr == t_addr);
   assign both    = !l_empty && !t_empty;

   always_comb begin
      if (!both)                   verdict = VD_WAIT;
      else if (!(data_eq && addr_eq)) verdict = VD_DIFFER;
      else if (fault)              verdict = VD_HELD;
      else                         verdict = VD_AGREE;
   end

   assign cw_valid = (verdict == VD_AGREE);
   assign cw_addr  = l_addr;
   assign cw_data  = l_data;
   assign pop_l    = cw_valid && cw_ready;
   assign pop_t    = cw_valid && cw_ready;
   assign mismatch = (verdict == VD_DIFFER);
endmodule

// File: rtl/rsc_load_cmp.sv
module rsc_load_cmp #(
   parameter int AW = 32
) (
   input  logic          l_valid,
   input  logic          l_uncached,
   input  logic [AW-1:0] l_addr,
   input  logic          t_valid,
   input  logic          t_uncached,
   input  logic [AW-1:0] t_addr,
   input  logic          fault,
   input  logic          req_ready,
   output logic          req_valid,
   output logic [AW-1:0] req_addr,
   output logic          l_ack,
   output logic          t_ack,
   output logic          mismatch
);
   logic l_unc, t_unc, both_unc, addr_eq, accept;

   assign l_unc     = l_valid && l_uncached;
   assign t_unc     = t_valid && t_uncached;
   assign both_unc  = l_unc && t_unc;
   assign addr_eq   = (l_addr == t_addr);
   assign req_valid = both_unc && addr_eq && !fault;
   assign req_addr  = l_addr;
   assign accept    = req_valid && req_ready;
   // cached loads take their data inside the region, so no pairing is needed
   assign l_ack     = (l_valid && !l_uncached) || accept;
   assign t_ack     = (t_valid && !t_uncached) || accept;
   assign mismatch  = both_unc && !addr_eq;
endmodule

// File: rtl/redundant_store_cmp.sv
module redundant_store_cmp #(
   parameter int AW      = 32,
   parameter int DW      = 64,
   parameter int DEPTH   = 64,
   parameter int CHUNK_W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lead_st_valid_i,
   input  logic [AW-1:0] lead_st_addr_i,
   input  logic [DW-1:0] lead_st_data_i,
   output logic          lead_full_o,
   input  logic          trail_st_valid_i,
   input  logic [AW-1:0] trail_st_addr_i,
   input  logic [DW-1:0] trail_st_data_i,
   output logic          trail_full_o,
   output logic          cw_valid_o,
   output logic [AW-1:0] cw_addr_o,
   output logic [DW-1:0] cw_data_o,
   input  logic          cw_ready_i,
   input  logic          lead_ld_valid_i,
   input  logic          lead_ld_uncached_i,
   input  logic [AW-1:0] lead_ld_addr_i,
   output logic          lead_ld_ack_o,
   input  logic          trail_ld_valid_i,
   input  logic          trail_ld_uncached_i,
   input  logic [AW-1:0] trail_ld_addr_i,
   output logic          trail_ld_ack_o,
   output logic          ul_req_valid_o,
   output logic [AW-1:0] ul_req_addr_o,
   input  logic          ul_req_ready_i,
   input  logic          fault_clr_i,
   output logic          fault_o
);
   localparam int EW = AW + DW;

   generate
      if (AW < 1 || DW < 1) begin : g_bad_widths
         $error("redundant_store_cmp: AW and DW must be positive");
      end
   endgenerate

   logic [EW-1:0] lead_head, trail_head;
   logic          lead_empty, trail_empty;
   logic          lead_pop, trail_pop;
   logic          st_mismatch, ld_mismatch;
   logic          fault_q;

   rsc_queue #(.DEPTH(DEPTH), .W(EW)) u_lead_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (lead_st_valid_i),
      .push_data ({lead_st_addr_i, lead_st_data_i}),
      .pop       (lead_pop),
      .head      (lead_head),
      .empty     (lead_empty),
      .full      (lead_full_o)
   );

   rsc_queue #(.DEPTH(DEPTH), .W(EW)) u_trail_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (trail_st_valid_i),
      .push_data ({trail_st_addr_i, trail_st_data_i}),
      .pop       (trail_pop),
      .head      (trail_head),
      .empty     (trail_empty),
      .full      (trail_full_o)
   );

   rsc_store_cmp #(.AW(AW), .DW(DW), .CHUNK_W(CHUNK_W)) u_st_cmp (
      .l_empty  (lead_empty),
      .t_empty  (trail_empty),
      .l_addr   (lead_head[EW-1:DW]),
      .t_addr   (trail_head[EW-1:DW]),
      .l_data   (lead_head[DW-1:0]),
      .t_data   (trail_head[DW-1:0]),
      .fault    (fault_q),
      .cw_ready (cw_ready_i),
      .cw_valid (cw_valid_o),
      .cw_addr  (cw_addr_o),
      .cw_data  (cw_data_o),
      .pop_l    (lead_pop),
      .pop_t    (trail_pop),
      .mismatch (st_mismatch)
   );

   rsc_load_cmp #(.AW(AW)) u_ld_cmp (
      .l_valid    (lead_ld_valid_i),
      .l_uncached (lead_ld_uncached_i),
      .l_addr     (lead_ld_addr_i),
      .t_valid    (trail_ld_valid_i),
      .t_uncached (trail_ld_uncached_i),
      .t_addr     (trail_ld_addr_i),
      .fault      (fault_q),
      .req_ready  (ul_req_ready_i),
      .req_valid  (ul_req_valid_o),
      .req_addr   (ul_req_addr_o),
      .l_ack      (lead_ld_ack_o),
      .t_ack      (trail_ld_ack_o),
      .mismatch   (ld_mismatch)
   );

   // A live disagreement outranks the clear so a persisting fault is not lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_q <= 1'b0;
      else        fault_q <= st_mismatch || ld_mismatch || (fault_q && !fault_clr_i);
   end

   assign fault_o = fault_q;
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
   parameter int AW = 32,
   parameter int DW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cw_valid_o,
   input logic [AW-1:0] cw_addr_o,
   input logic [DW-1:0] cw_data_o,
   input logic          cw_ready_i,
   input logic          lead_empty,
   input logic          trail_empty,
   input logic          lead_pop,
   input logic          trail_pop,
   input logic          lead_ld_valid_i,
   input logic          lead_ld_uncached_i,
   input logic [AW-1:0] lead_ld_addr_i,
   input logic          lead_ld_ack_o,
   input logic          trail_ld_valid_i,
   input logic          trail_ld_uncached_i,
   input logic [AW-1:0] trail_ld_addr_i,
   input logic          ul_req_valid_o,
   input logic          fault_clr_i,
   input logic          fault_o
);
   // R2
   wait_for_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_empty || trail_empty) |-> !cw_valid_o);

   // R3
   paired_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lead_pop == trail_pop);

   // R4
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && !fault_clr_i) |=> fault_o);

   // R5
   fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (!cw_valid_o && !ul_req_valid_o));

   // R8
   ul_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ul_req_valid_o |-> (lead_ld_valid_i && trail_ld_valid_i && lead_ld_uncached_i
                          && trail_ld_uncached_i && lead_ld_addr_i == trail_ld_addr_i));

   // R10
   cached_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_ld_valid_i && !lead_ld_uncached_i) |-> lead_ld_ack_o);

   // R11
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_valid_o && !cw_ready_i) |=>
         (fault_o || (cw_valid_o && $stable(cw_addr_o) && $stable(cw_data_o))));
endmodule

bind redundant_store_cmp rsc_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk                 (clk),
   .rst_n               (rst_n),
   .cw_valid_o          (cw_valid_o),
   .cw_addr_o           (cw_addr_o),
   .cw_data_o           (cw_data_o),
   .cw_ready_i          (cw_ready_i),
   .lead_empty          (lead_empty),
   .trail_empty         (trail_empty),
   .lead_pop            (lead_pop),
   .trail_pop           (trail_pop),
   .lead_ld_valid_i     (lead_ld_valid_i),
   .lead_ld_uncached_i  (lead_ld_uncached_i),
   .lead_ld_addr_i      (lead_ld_addr_i),
   .lead_ld_ack_o       (lead_ld_ack_o),
   .trail_ld_valid_i    (trail_ld_valid_i),
   .trail_ld_uncached_i (trail_ld_uncached_i),
   .trail_ld_addr_i     (trail_ld_addr_i),
   .ul_req_valid_o      (ul_req_valid_o),
   .fault_clr_i         (fault_clr_i),
   .fault_o             (fault_o)
);

// File: tb/tb_redundant_store_cmp.sv
module tb_redundant_store_cmp;
   localparam int AW = 32;
   localparam int DW = 64;
   localparam int DEPTH = 64;
   localparam int EW = AW + DW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          lead_st_valid_i, trail_st_valid_i;
   logic [AW-1:0] lead_st_addr_i, trail_st_addr_i;
   logic [DW-1:0] lead_st_data_i, trail_st_data_i;
   logic          lead_full_o, trail_full_o;
   logic          cw_valid_o, cw_ready_i;
   logic [AW-1:0] cw_addr_o;
   logic [DW-1:0] cw_data_o;
   logic          lead_ld_valid_i, lead_ld_uncached_i, lead_ld_ack_o;
   logic          trail_ld_valid_i, trail_ld_uncached_i, trail_ld_ack_o;
   logic [AW-1:0] lead_ld_addr_i, trail_ld_addr_i, ul_req_addr_o;
   logic          ul_req_valid_o, ul_req_ready_i;
   logic          fault_clr_i, fault_o;

   redundant_store_cmp #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (.*);

   int checks = 0;
   int failures = 0;
   logic [EW-1:0] qL[$];
   logic [EW-1:0] qT[$];
   bit fault_m = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [EW-1:0] gen(input int i);
      return {32'h4000_0000 + 32'(i) * 32'd4, 32'(i) * 32'h9E37_79B9, ~32'(i)};
   endfunction

   task automatic idle_inputs();
      lead_st_valid_i = 0; trail_st_valid_i = 0;
      lead_st_addr_i = '0; lead_st_data_i = '0;
      trail_st_addr_i = '0; trail_st_data_i = '0;
      cw_ready_i = 0; ul_req_ready_i = 0; fault_clr_i = 0;
      lead_ld_valid_i = 0; lead_ld_uncached_i = 0; lead_ld_addr_i = '0;
      trail_ld_valid_i = 0; trail_ld_uncached_i = 0; trail_ld_addr_i = '0;
   endtask

   task automatic push_lead(input logic [EW-1:0] e);
      lead_st_valid_i = 1; {lead_st_addr_i, lead_st_data_i} = e;
   endtask

   task automatic push_trail(input logic [EW-1:0] e);
      trail_st_valid_i = 1; {trail_st_addr_i, trail_st_data_i} = e;
   endtask

   // Checks one cycle against the model, then advances the model across the edge
   task automatic cycle();
      bit bothv, st_eq, exp_cw, ul_both, exp_ul, exp_la, exp_ta, st_mis, ld_mis;
      bit do_pop, pl, pt;
      #2;
      bothv  = qL.size() != 0 && qT.size() != 0;
      st_eq  = bothv && (qL[0] == qT[0]);
      exp_cw = st_eq && !fault_m;
      chk(cw_valid_o === exp_cw, "R1", 128'(cw_valid_o), 128'(exp_cw));
      if (exp_cw) chk({cw_addr_o, cw_data_o} === qL[0], "R3", 128'({cw_addr_o, cw_data_o}), 128'(qL[0]));
      chk(lead_full_o === (qL.size() == DEPTH), "R7", 128'(lead_full_o), 128'(qL.size() == DEPTH));
      chk(trail_full_o === (qT.size() == DEPTH), "R7", 128'(trail_full_o), 128'(qT.size() == DEPTH));
      chk(fault_o === fault_m, "R4", 128'(fault_o), 128'(fault_m));
      ul_both = lead_ld_valid_i && lead_ld_uncached_i && trail_ld_valid_i && trail_ld_uncached_i;
      exp_ul  = ul_both && (lead_ld_addr_i == trail_ld_addr_i) && !fault_m;
      chk(ul_req_valid_o === exp_ul, "R8", 128'(ul_req_valid_o), 128'(exp_ul));
      if (exp_ul) chk(ul_req_addr_o === lead_ld_addr_i, "R8", 128'(ul_req_addr_o), 128'(lead_ld_addr_i));
      exp_la = (lead_ld_valid_i && !lead_ld_uncached_i) || (exp_ul && ul_req_ready_i);
      exp_ta = (trail_ld_valid_i && !trail_ld_uncached_i) || (exp_ul && ul_req_ready_i);
      chk(lead_ld_ack_o === exp_la, "R10", 128'(lead_ld_ack_o), 128'(exp_la));
      chk(trail_ld_ack_o === exp_ta, "R10", 128'(trail_ld_ack_o), 128'(exp_ta));
      ld_mis = ul_both && (lead_ld_addr_i != trail_ld_addr_i);
      st_mis = bothv && !st_eq;
      do_pop = exp_cw && cw_ready_i;
      pl = lead_st_valid_i && qL.size() < DEPTH;
      pt = trail_st_valid_i && qT.size() < DEPTH;
      fault_m = st_mis || ld_mis || (fault_m && !fault_clr_i);
      if (do_pop) begin void'(qL.pop_front()); void'(qT.pop_front()); end
      if (pl) qL.push_back({lead_st_addr_i, lead_st_data_i});
      if (pt) qT.push_back({trail_st_addr_i, trail_st_data_i});
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_n = 0;
      qL.delete(); qT.delete(); fault_m = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int lidx, tidx;
      void'($urandom(32'h5EED_0001));
      do_reset();

      // R12 reset state
      #1;
      chk(!cw_valid_o && !fault_o && !ul_req_valid_o && !lead_full_o && !trail_full_o, "R12",
          128'({cw_valid_o, fault_o, ul_req_valid_o, lead_full_o, trail_full_o}), 128'(0));
      cycle();

      // R2: lead waits alone
      for (int i = 0; i < 3; i++) begin idle_inputs(); cw_ready_i = 1; push_lead(gen(i)); cycle(); end
      idle_inputs(); cw_ready_i = 1;
      for (int i = 0; i < 4; i++) begin
         #1; chk(cw_valid_o == 0, "R2", 128'(cw_valid_o), 128'(0));
         cycle();
      end
      for (int i = 0; i < 3; i++) begin idle_inputs(); cw_ready_i = 1; push_trail(gen(i)); cycle(); end
      idle_inputs(); cw_ready_i = 1;
      repeat (5) cycle();

      // R7 and R11: fill lead, drop overflow push, hold offer while cache stalls
      do_reset();
      for (int i = 0; i < DEPTH; i++) begin idle_inputs(); push_lead(gen(100 + i)); cycle(); end
      idle_inputs(); push_lead(gen(999));
      #1; chk(lead_full_o == 1, "R7", 128'(lead_full_o), 128'(1));
      cycle();
      idle_inputs(); push_trail(gen(100)); cycle();
      for (int i = 1; i < DEPTH; i++) begin
         idle_inputs(); push_trail(gen(100 + i));
         #1; chk(cw_valid_o && {cw_addr_o, cw_data_o} == gen(100), "R11",
                 128'({cw_addr_o, cw_data_o}), 128'(gen(100)));
         cycle();
      end
      idle_inputs(); cw_ready_i = 1;
      repeat (DEPTH + 2) cycle();
      #1; chk(!fault_o && !cw_valid_o, "R7", 128'({fault_o, cw_valid_o}), 128'(0));
      cycle();

      // R9, R5, R6: transient uncached mismatch, stall, then clear
      do_reset();
      push_lead(gen(7)); push_trail(gen(7));
      lead_ld_valid_i = 1; lead_ld_uncached_i = 1; lead_ld_addr_i = 32'h100;
      trail_ld_valid_i = 1; trail_ld_uncached_i = 1; trail_ld_addr_i = 32'h104;
      cycle();
      idle_inputs(); cw_ready_i = 1; ul_req_ready_i = 1;
      lead_ld_valid_i = 1; lead_ld_uncached_i = 1; lead_ld_addr_i = 32'h200;
      trail_ld_valid_i = 1; trail_ld_uncached_i = 1; trail_ld_addr_i = 32'h200;
      #1; chk(fault_o == 1, "R9", 128'(fault_o), 128'(1));
      chk(!cw_valid_o && !ul_req_valid_o, "R5", 128'({cw_valid_o, ul_req_valid_o}), 128'(0));
      cycle();
      fault_clr_i = 1; cycle();
      fault_clr_i = 0;
      #1; chk(fault_o == 0 && cw_valid_o == 1, "R6", 128'({fault_o, cw_valid_o}), 128'(2'b01));
      cycle();
      idle_inputs(); cw_ready_i = 1; repeat (3) cycle();

      // R4: store data mismatch persists past a clear
      do_reset();
      push_lead(gen(3));
      push_trail(gen(3) ^ {{AW{1'b0}}, 64'h1});
      cycle();
      idle_inputs(); cw_ready_i = 1; cycle();
      #1; chk(fault_o == 1, "R4", 128'(fault_o), 128'(1));
      fault_clr_i = 1; cycle();
      fault_clr_i = 0;
      #1; chk(fault_o == 1 && cw_valid_o == 0, "R4", 128'({fault_o, cw_valid_o}), 128'(2'b10));
      cycle();

      // R10: cached loads with differing addresses, one thread alone
      do_reset();
      lead_ld_valid_i = 1; lead_ld_addr_i = 32'h10;
      #1; chk(lead_ld_ack_o == 1 && ul_req_valid_o == 0, "R10", 128'({lead_ld_ack_o, ul_req_valid_o}), 128'(2'b10));
      cycle();
      trail_ld_valid_i = 1; trail_ld_addr_i = 32'h20; cycle();
      idle_inputs();
      #1; chk(fault_o == 0, "R10", 128'(fault_o), 128'(0));
      cycle();

      // Random phase: skewed but identical streams, random back-pressure and loads
      do_reset();
      lidx = 0; tidx = 0;
      for (int c = 0; c < 4000; c++) begin
         idle_inputs();
         if ($urandom_range(1, 0) == 1 && qL.size() < DEPTH) begin push_lead(gen(lidx)); lidx++; end
         if ($urandom_range(2, 0) != 0 && qT.size() < DEPTH) begin push_trail(gen(tidx)); tidx++; end
         cw_ready_i = ($urandom_range(3, 0) != 0);
         ul_req_ready_i = $urandom_range(1, 0) == 1;
         lead_ld_valid_i = $urandom_range(1, 0) == 1;
         lead_ld_uncached_i = $urandom_range(3, 0) == 0;
         lead_ld_addr_i = 32'h8000 + 32'($urandom_range(7, 0)) * 4;
         if ($urandom_range(1, 0) == 1) begin
            trail_ld_valid_i = lead_ld_valid_i;
            trail_ld_uncached_i = lead_ld_uncached_i;
            trail_ld_addr_i = lead_ld_addr_i;
         end else begin
            trail_ld_valid_i = $urandom_range(1, 0) == 1;
            trail_ld_uncached_i = 1'b0;
            trail_ld_addr_i = 32'h9000;
         end
         cycle();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule